// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

A memory-mapped watchdog for a system bus. It counts down from a software-chosen 16-bit reload value through a power-of-two prescaler. When the count runs out, it raises a one-clock reset request to the system reset logic. It also remembers, across that system reset, that the watchdog was the cause.

The control register can only be changed through a two-write key sequence. Software first writes a fixed unlock word. The very next control-register write must carry a second key byte, and it supplies the whole new configuration in the same word. That configuration holds the enable, power, divider and reload fields. Every action on the watchdog goes through this sequence: start, refresh (reloading the counter) and stop. Any control write that breaks the sequence is dropped and discards the unlock.

The block has two resets. The power-on reset `por_n` clears everything. The system reset `rst_n` clears everything except the reset-cause flag, so software can read the cause after a reboot.

Top module: `pwd_watchdog`

## Requirements
- R1: After power-on reset, a read of the status register returns 0 and `rst_req` is low.
- R2: A write of exactly 0x00BE0000 to address 0x0 arms the unlock. If the next write to 0x0 has 0xDC in bits 23:16, it loads the configuration: bit 31 enable, bits 27:26 power, bits 25:24 divider code, bits 15:0 reload. The same write loads the counter from the reload field.
- R3: A control write that is neither the unlock word nor a keyed write while armed leaves configuration and counter unchanged and disarms. The dropped cases are a wrong unlock word, a keyed word without prior unlock, and a write after unlock whose bits 23:16 are not 0xDC.
- R4: The counter decrements once per prescaled tick, and only while enable is 1 and power is 2'b11. Otherwise the counter and prescaler hold. Divider code c divides the clock by 2^(6·c), so code 3 divides by 262144.
- R5: With reload N (N=0 treated as 1) and divider D, `rst_req` is high for exactly one cycle, N·D clock edges after the loading write. After that, enable reads 0 and the counter reads 0.
- R6: Expiry sets the reset-cause flag (status bit 16). The flag survives `rst_n` and is cleared only by `por_n`.
- R7: Repeating the key sequence while running reloads the counter and restarts the prescaler, so expiry is measured from the refresh write.
- R8: A keyed write with all configuration bits zero stops the watchdog: status fields read 0 and no reset request follows.
- R9: The status register at 0x8 reads {enable[31], 0[30:28], power[27:26], divider[25:24], 0[23:17], cause[16], counter[15:0]}. Every other address reads 0.
- R10: A low `rst_n` clears configuration, counter and a pending unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears all state |
| rst_n | input | 1 | System reset, synchronous, active low; keeps the cause flag |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
Expiry timing is tried with a table of reload and divider pairs: reload 0 and 1, small and mid reloads on the undivided clock, and the two middle divider codes. These patterns separate a counter that is off by one, a mis-scaled prescaler and a wrong treatment of reload 0. The key sequence is attacked with a wrong unlock word, a keyed word without unlock, and an unlock followed by a wrong key. Each must leave a frozen configuration intact. Refresh, stop, power gating and the largest divider are checked through the status register, and the sticky cause is checked across both resets.

// File: rtl/pwd_wdt_pkg.sv
package pwd_wdt_pkg;
    localparam logic [31:0] UNLOCK_WORD = 32'h00BE_0000;
    localparam logic [7:0]  KEY_TWO     = 8'hDC;
    localparam int          KEY_LO      = 16;
    localparam int          EN_BIT      = 31;
    localparam int          PWR_LO      = 26;
    localparam int          DIV_LO      = 24;
    localparam int          RELOAD_W    = 16;
    localparam int          CTRL_OFS    = 0;
    localparam int          STAT_OFS    = 8;

    typedef struct packed {
        logic       en;
        logic [1:0] pwr;
        logic [1:0] div;
    } cfg_t;
endpackage

// File: rtl/pwd_wdt_unlock.sv
module pwd_wdt_unlock
    import pwd_wdt_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        soft_rst,
    input  logic        wr_ctrl,
    input  logic [31:0] wdata,
    output logic        apply
);
    typedef struct packed { logic armed; } ul_t;
    ul_t st_d, st_q;

    assign apply = wr_ctrl && !soft_rst && st_q.armed
                   && (wdata[KEY_LO +: 8] == KEY_TWO);

    always_comb begin
        st_d = st_q;
        if (soft_rst)
            st_d.armed = 1'b0;
        else if (wr_ctrl)
            st_d.armed = (wdata == UNLOCK_WORD);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    arm_source_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(st_q.armed) |-> ($past(wr_ctrl) && $past(wdata) == UNLOCK_WORD));
    // R2
    apply_disarm_chk: assert property (@(posedge clk) disable iff (!por_n)
        apply |=> !st_q.armed);
endmodule

// File: rtl/pwd_wdt_prescale.sv
module pwd_wdt_prescale #(
    parameter int STEP_LOG2 = 6,
    parameter int CODES     = 4
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     soft_rst,
    input  logic                     clear,
    input  logic                     run,
    input  logic [$clog2(CODES)-1:0] div_code,
    output logic                     tick
);
    localparam int PRE_W = STEP_LOG2 * (CODES - 1);

    typedef struct packed { logic [PRE_W-1:0] pre; } ps_t;
    ps_t st_d, st_q;

    logic [PRE_W-1:0] mask_tab [CODES];
    logic [PRE_W-1:0] mask;

    for (genvar g = 0; g < CODES; g++) begin : g_mask
        assign mask_tab[g] = PRE_W'((64'd1 << (g * STEP_LOG2)) - 64'd1);
    end

    assign mask = mask_tab[div_code];
    assign tick = run && !soft_rst && ((st_q.pre & mask) == mask);

    always_comb begin
        st_d = st_q;
        if (soft_rst || clear)
            st_d.pre = '0;
        else if (run)
            st_d.pre = tick ? '0 : st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    frozen_pre_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!run && !clear && !soft_rst) |=> $stable(st_q.pre));
endmodule

// File: rtl/pwd_wdt_countdown.sv
module pwd_wdt_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    typedef struct packed { logic [CNT_W-1:0] cnt; } cd_t;
    cd_t st_d, st_q;

    logic last;
    assign last   = (st_q.cnt <= CNT_W'(1));
    assign expire = tick && !load && !soft_rst && last;
    assign count  = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (soft_rst)
            st_d.cnt = '0;
        else if (load)
            st_d.cnt = load_val;
        else if (tick)
            st_d.cnt = last ? '0 : st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!tick && !load && !soft_rst) |=> $stable(st_q.cnt));
    // R5
    expire_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        expire |=> (st_q.cnt == '0));
endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
    import pwd_wdt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int STEP_LOG2 = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req
);
    typedef struct packed {
        cfg_t cfg;
        logic req;
        logic cause;
    } top_t;
    top_t st_d, st_q;

    logic                soft_rst, wr_ctrl, apply, run, tick, expire;
    logic [RELOAD_W-1:0] count;

    assign soft_rst = !rst_n;
    assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));
    assign run      = st_q.cfg.en && (st_q.cfg.pwr == 2'b11);

    pwd_wdt_unlock u_unlock (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
        .wr_ctrl(wr_ctrl), .wdata(bus_wdata), .apply(apply)
    );

    pwd_wdt_prescale #(.STEP_LOG2(STEP_LOG2), .CODES(4)) u_pre (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .clear(apply),
        .run(run), .div_code(st_q.cfg.div), .tick(tick)
    );

    pwd_wdt_countdown #(.CNT_W(RELOAD_W)) u_cnt (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .load(apply),
        .load_val(bus_wdata[RELOAD_W-1:0]), .tick(tick),
        .count(count), .expire(expire)
    );

    always_comb begin
        st_d       = st_q;
        st_d.req   = expire;
        st_d.cause = st_q.cause | expire;
        if (soft_rst) begin
            st_d.cfg = '0;
        end else if (apply) begin
            st_d.cfg.en  = bus_wdata[EN_BIT];
            st_d.cfg.pwr = bus_wdata[PWR_LO +: 2];
            st_d.cfg.div = bus_wdata[DIV_LO +: 2];
        end else if (expire) begin
            st_d.cfg.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_req = st_q.req;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(STAT_OFS))
            bus_rdata = {st_q.cfg.en, 3'b000, st_q.cfg.pwr, st_q.cfg.div,
                         7'b0000000, st_q.cause, count};
    end

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);
    // R5
    req_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> st_q.cause);
    // R6
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        st_q.cause |=> st_q.cause);
    // R8
    disable_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
        (apply && !bus_wdata[EN_BIT]) |=> !st_q.cfg.en);
endmodule

// File: tb/pwd_watchdog_test.sv
module pwd_watchdog_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pwd_watchdog uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    typedef struct packed {
        logic [1:0]  div;
        logic [15:0] reload;
        logic [31:0] edges;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 16'd5,   32'd5},
        '{2'd0, 16'd1,   32'd1},
        '{2'd0, 16'd0,   32'd1},
        '{2'd0, 16'd300, 32'd300},
        '{2'd1, 16'd3,   32'd192},
        '{2'd1, 16'd1,   32'd64},
        '{2'd2, 16'd1,   32'd4096}
    };

    function automatic logic [31:0] cfg_word(logic en, logic [1:0] pwr,
                                             logic [1:0] div, logic [15:0] rl);
        return 32'h00DC_0000 | {en, 31'd0} | {4'd0, pwr, 26'd0}
               | {6'd0, div, 24'd0} | {16'd0, rl};
    endfunction

    function automatic logic [31:0] stat_word(logic en, logic [1:0] pwr,
            logic [1:0] div, logic cause, logic [15:0] cnt);
        return {en, 3'b000, pwr, div, 7'd0, cause, cnt};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic keyed(logic [31:0] w);
        bus_write(4'h0, 32'h00BE_0000);
        bus_write(4'h0, w);
    endtask

    task automatic read_at(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic soft_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wait_quiet(int n, output bit seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) seen = 1;
        end
    endtask

    task automatic edges_to_req(output int n);
        bit hit;
        n = 0; hit = 0;
        while (!hit && n < 20000) begin
            @(negedge clk);
            n++;
            if (rst_req) hit = 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        bit seen;
        int n;

        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_at(4'h8, rd); check("R1 status after por", rd, 32'h0);
        check("R1 rst_req after por", {31'd0, rst_req}, 32'h0);

        // R9 unmapped and control reads
        read_at(4'h0, rd); check("R9 read control addr", rd, 32'h0);
        read_at(4'h4, rd); check("R9 read addr 4", rd, 32'h0);

        // R2 load and read back, R4 decrement on undivided clock
        keyed(cfg_word(1, 2'b11, 2'd0, 16'h0123));
        read_at(4'h8, rd); check("R2 config readback", rd, 32'h8C00_0123);
        repeat (16) @(negedge clk);
        read_at(4'h8, rd); check("R4 count after 16 ticks", rd, 32'h8C00_0113);

        // R10 soft reset clears config and pending unlock
        soft_reset();
        read_at(4'h8, rd); check("R10 status after rst_n", rd, 32'h0);
        bus_write(4'h0, 32'h00BE_0000);
        soft_reset();
        bus_write(4'h0, cfg_word(1, 2'b11, 2'd0, 16'd9));
        read_at(4'h8, rd); check("R10 unlock dropped by rst_n", rd, 32'h0);

        // R4 power off freezes counter
        keyed(cfg_word(1, 2'b00, 2'd0, 16'd20));
        wait_quiet(30, seen);
        read_at(4'h8, rd); check("R4 frozen when power off", rd, 32'h8000_0014);
        check("R4 no request when power off", {31'd0, seen}, 32'h0);

        // R3 broken sequences
        bus_write(4'h0, cfg_word(1, 2'b11, 2'd0, 16'd9));
        read_at(4'h8, rd); check("R3 key without unlock", rd, 32'h8000_0014);
        bus_write(4'h0, 32'h00BE_0000);
        bus_write(4'h0, 32'h80AC_0005);
        bus_write(4'h0, cfg_word(1, 2'b11, 2'd0, 16'd9));
        read_at(4'h8, rd); check("R3 wrong second key", rd, 32'h8000_0014);
        bus_write(4'h0, 32'h00BE_0001);
        bus_write(4'h0, cfg_word(1, 2'b11, 2'd0, 16'd9));
        read_at(4'h8, rd); check("R3 wrong unlock word", rd, 32'h8000_0014);

        // R4 largest divider: no decrement within 2000 cycles
        keyed(cfg_word(1, 2'b11, 2'd3, 16'd2));
        wait_quiet(2000, seen);
        read_at(4'h8, rd); check("R4 divider code 3 holds", rd, 32'h8F00_0002);

        // R8 stop
        keyed(cfg_word(1, 2'b11, 2'd0, 16'd50));
        keyed(32'h00DC_0000);
        read_at(4'h8, rd); check("R8 status after stop", rd, 32'h0);
        wait_quiet(100, seen);
        check("R8 no request after stop", {31'd0, seen}, 32'h0);

        // R7 refresh restarts the countdown
        soft_reset();
        keyed(cfg_word(1, 2'b11, 2'd0, 16'd10));
        wait_quiet(6, seen);
        keyed(cfg_word(1, 2'b11, 2'd0, 16'd10));
        edges_to_req(n);
        check("R7 expiry measured from refresh", 32'(n), 32'd10);
        check("R7 no early request", {31'd0, seen}, 32'h0);

        // R5 expiry timing table
        foreach (VECS[i]) begin
            soft_reset();
            keyed(cfg_word(1, 2'b11, VECS[i].div, VECS[i].reload));
            edges_to_req(n);
            check($sformatf("R5 vec %0d edges to request", i), 32'(n), VECS[i].edges);
            @(negedge clk);
            check($sformatf("R5 vec %0d one-cycle pulse", i), {31'd0, rst_req}, 32'h0);
            read_at(4'h8, rd);
            check($sformatf("R5 vec %0d status after expiry", i), rd,
                  stat_word(0, 2'b11, VECS[i].div, 1, 16'd0));
        end

        // R6 cause survives rst_n, cleared by por_n
        soft_reset();
        read_at(4'h8, rd); check("R6 cause kept over rst_n", rd, 32'h0001_0000);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        read_at(4'h8, rd); check("R6 cause cleared by por_n", rd, 32'h0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule